// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block lets a host drive a raw 8-bit NAND flash device through a single 32-bit register word. Each host write to the word carries a cycle-type opcode, a chip-enable request and one byte. The bridge turns that write into a timed flash bus cycle. Command cycles raise CLE, address cycles raise ALE, and data writes raise neither. In all three the bridge drives the byte on the flash data pins and pulses WE# low for a fixed number of clocks. The bridge holds one clock of data setup before the falling edge of WE# and one clock of hold after its rising edge.

One opcode puts the bridge into read mode. In read mode every host read of the word makes one RE# low pulse on the flash. The bridge latches the byte the flash returns and hands it back in the read word. The host needs no write between reads. Every host read also returns the flash ready/busy state. That state is taken from the active-low ready/busy pin through a two-stage synchroniser. A wait output stalls the host while a flash cycle is running. A write that arrives during a cycle is held off until the cycle ends. The host must keep its request asserted until the wait output drops.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, WE#, RE# and CE# are high, CLE, ALE and the data-out enable are low, the wait output is low, and a host read returns an all-zero word.
- R2: An accepted write with opcode 0 in bits 30:28 makes one command cycle. CLE is high and ALE is low for the whole cycle, and the flash bus carries the byte from bits 23:16.
- R3: An accepted write with opcode 1 makes one address cycle. ALE is high and CLE is low for the whole cycle, and the flash bus carries the byte from bits 23:16.
- R4: Each accepted write with opcode 3 makes exactly one WE# low pulse, with CLE and ALE both low.
- R5: WE# stays low for PULSE_CLKS clocks (default 2). The data-out enable and the byte are present for one clock before WE# falls and one clock after it rises, and the byte does not change while it is driven.
- R6: Bit 31 of a write with opcode 0 to 3 sets the CE# level: 1 drives CE# low, 0 drives it high. That level holds until the next such write.
- R7: A flash cycle keeps the wait output high from the clock after acceptance for PULSE_CLKS+2 clocks. A write held during that time is carried out after the cycle ends, with its own byte.
- R8: A write with opcode 2 makes no WE# pulse and arms read mode. Each host read then makes one RE# low pulse of PULSE_CLKS clocks. The wait output stays high until the byte sampled from the flash at the end of that pulse is shown in bits 23:16 of the read word.
- R9: A host read while read mode is not armed makes no RE# pulse and does not wait. It returns the byte from the last read cycle in bits 23:16.
- R10: Bit 15 of the read word is 1 while the ready/busy input is low (busy) and 0 while it is high. It follows that input two clocks late. All other bits of the read word outside 23:16 and 15 are zero.
- R11: A write with an opcode from 4 to 7 makes no flash cycle and leaves CE# unchanged. It does disarm read mode.
- R12: A write with opcode 0, 1 or 3 disarms read mode, so a later host read makes no RE# pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write request, held until wait is low |
| hostRd | input | 1 | Host read request, held until wait is low |
| hostWdata | input | 32 | Host write word: CE request, opcode, byte |
| hostRdata | output | 32 | Host read word: flash byte and busy flag |
| hostWait | output | 1 | Stalls the host while a cycle or a read is pending |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashCle | output | 1 | Flash command latch enable |
| flashAle | output | 1 | Flash address latch enable |
| flashWeN | output | 1 | Flash write strobe, active low |
| flashReN | output | 1 | Flash read strobe, active low |
| flashDout | output | 8 | Byte driven toward the flash |
| flashDoutEn | output | 1 | Output enable for the flash data pins |
| flashDin | input | 8 | Byte coming from the flash |
| flashRbN | input | 1 | Flash ready/busy, low while busy |

## Verification
The bench goes after held writes that arrive during a running cycle. A bridge that let such a write through would restart the sequencer, swap the driven byte in mid-pulse and shorten WE#. The bench also reads right after opcodes 3 and 5. A bridge that left read mode armed after those would raise a stray RE# pulse, and a host read would then stall. The bench checks the exact clock on which the read byte appears and the clock on which the busy flag changes. An off-by-one in the RE# sampling point would return the previous flash byte, and a missing synchroniser stage would move the busy flag one clock early. An ignored opcode that still loaded the chip-enable bit would release CE# on the flash.

// File: rtl/nandbr_pkg.sv
package nandbr_pkg;
  localparam int REG_W    = 32;
  localparam int BYTE_W   = 8;
  localparam int OP_LSB   = 28;
  localparam int OP_W     = 3;
  localparam int CE_BIT   = 31;
  localparam int BYTE_LSB = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [OP_W-1:0] OP_CMD   = 3'd0;
  localparam logic [OP_W-1:0] OP_ADDR  = 3'd1;
  localparam logic [OP_W-1:0] OP_RDARM = 3'd2;
  localparam logic [OP_W-1:0] OP_DWR   = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD
  } seqState_e;

  typedef enum logic [1:0] {
    K_CMD,
    K_ADDR,
    K_DWR,
    K_READ
  } cycKind_e;

  typedef struct packed {
    logic loadByte;
    logic loadCe;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/nandbr_ctrl.sv
module nandbr_ctrl
  import nandbr_pkg::*;
#(
  parameter int PULSE_CLKS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hostWr,
  input  logic            hostRd,
  input  logic [OP_W-1:0] wrOp,
  output dpStrobe_t       strobe,
  output logic            flashCle,
  output logic            flashAle,
  output logic            flashWeN,
  output logic            flashReN,
  output logic            flashDoutEn,
  output logic            hostWait
);
  localparam int CNT_W = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CLKS - 1);
  localparam int RUN_W = CNT_W + 1;

  seqState_e        state;
  cycKind_e         kind;
  logic [CNT_W-1:0] cnt;
  logic             readArmed;
  logic             rdReady;

  logic idle, inCycle, opValid, opCycle, wrAccept, rdStart, pulseLast;

  function automatic cycKind_e opToKind(input logic [OP_W-1:0] op);
    case (op)
      OP_CMD:  return K_CMD;
      OP_ADDR: return K_ADDR;
      default: return K_DWR;
    endcase
  endfunction

  always_comb begin
    idle      = (state == ST_IDLE);
    inCycle   = !idle;
    opValid   = !wrOp[OP_W-1];
    opCycle   = opValid && (wrOp != OP_RDARM);
    wrAccept  = hostWr && idle;
    rdStart   = !hostWr && hostRd && readArmed && idle && !rdReady;
    pulseLast = (state == ST_PULSE) && (cnt == '0);
  end

  always_comb begin
    strobe.loadByte = wrAccept && opCycle;
    strobe.loadCe   = wrAccept && opValid;
    strobe.capture  = pulseLast && (kind == K_READ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_CMD;
      cnt       <= '0;
      readArmed <= 1'b0;
      rdReady   <= 1'b0;
    end else begin
      rdReady <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (wrAccept) begin
            readArmed <= (wrOp == OP_RDARM);
            if (opCycle) begin
              kind  <= opToKind(wrOp);
              state <= ST_SETUP;
            end
          end else if (rdStart) begin
            kind  <= K_READ;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt   <= CNT_LOAD;
          state <= ST_PULSE;
        end
        ST_PULSE: begin
          if (cnt == '0) begin
            if (kind == K_READ) begin
              rdReady <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              state <= ST_HOLD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    flashCle    = inCycle && (kind == K_CMD);
    flashAle    = inCycle && (kind == K_ADDR);
    flashDoutEn = inCycle && (kind != K_READ);
    flashWeN    = !((state == ST_PULSE) && (kind != K_READ));
    flashReN    = !((state == ST_PULSE) && (kind == K_READ));
    hostWait    = inCycle || (hostRd && !hostWr && readArmed && !rdReady);
  end

  // Run length of the current WE# low phase, kept for the pulse-width check.
  logic [RUN_W-1:0] weLowRun;
  always_ff @(posedge clk) begin
    if (!rstN)          weLowRun <= '0;
    else if (!flashWeN) weLowRun <= weLowRun + 1'b1;
    else                weLowRun <= '0;
  end

  p_cle_ale_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(flashCle && flashAle));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashReN));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> (weLowRun == RUN_W'(PULSE_CLKS)));

  p_we_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWeN) |-> $past(flashDoutEn));

  p_we_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> flashDoutEn);

  p_ignored_op_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostWait && wrOp[OP_W-1]) |=> (flashWeN && !flashDoutEn && flashReN));

  p_unarmed_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && idle && !readArmed) |=> flashReN);
endmodule

// File: rtl/nandbr_dpath.sv
module nandbr_dpath
  import nandbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              wrCe,
  input  logic [BYTE_W-1:0] flashDin,
  input  logic              flashRbN,
  output logic [BYTE_W-1:0] flashDout,
  output logic              flashCeN,
  output logic [REG_W-1:0]  hostRdata
);
  logic [BYTE_W-1:0] outByte;
  logic [BYTE_W-1:0] inByte;
  logic              ceOn;
  logic              rbSynced;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByte <= '0;
      inByte  <= '0;
      ceOn    <= 1'b0;
    end else begin
      if (strobe.loadByte) outByte <= wrByte;
      if (strobe.loadCe)   ceOn    <= wrCe;
      if (strobe.capture)  inByte  <= flashDin;
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      logic [SYNC_STAGES-1:0] rbPipe;
      always_ff @(posedge clk) begin
        if (!rstN) rbPipe <= '1;
        else       rbPipe <= {rbPipe[SYNC_STAGES-2:0], flashRbN};
      end
      assign rbSynced = rbPipe[SYNC_STAGES-1];
    end else begin : g_single
      logic rbOne;
      always_ff @(posedge clk) begin
        if (!rstN) rbOne <= 1'b1;
        else       rbOne <= flashRbN;
      end
      assign rbSynced = rbOne;
    end
  endgenerate

  always_comb begin
    hostRdata                           = '0;
    hostRdata[BYTE_LSB +: BYTE_W]       = inByte;
    hostRdata[BUSY_BIT]                 = !rbSynced;
    flashDout                           = outByte;
    flashCeN                            = !ceOn;
  end

  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(inByte));
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
  import nandbr_pkg::*;
#(
  parameter int PULSE_CLKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostWait,
  output logic        flashCeN,
  output logic        flashCle,
  output logic        flashAle,
  output logic        flashWeN,
  output logic        flashReN,
  output logic [7:0]  flashDout,
  output logic        flashDoutEn,
  input  logic [7:0]  flashDin,
  input  logic        flashRbN
);
  dpStrobe_t strobe;
  logic      unusedWdata;

  assign unusedWdata = ^{hostWdata[27:24], hostWdata[15:0]};

  nandbr_ctrl #(.PULSE_CLKS(PULSE_CLKS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .wrOp       (hostWdata[OP_LSB +: OP_W]),
    .strobe     (strobe),
    .flashCle   (flashCle),
    .flashAle   (flashAle),
    .flashWeN   (flashWeN),
    .flashReN   (flashReN),
    .flashDoutEn(flashDoutEn),
    .hostWait   (hostWait)
  );

  nandbr_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrByte   (hostWdata[BYTE_LSB +: BYTE_W]),
    .wrCe     (hostWdata[CE_BIT]),
    .flashDin (flashDin),
    .flashRbN (flashRbN),
    .flashDout(flashDout),
    .flashCeN (flashCeN),
    .hostRdata(hostRdata)
  );

  p_dout_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flashDoutEn && $past(flashDoutEn)) |-> $stable(flashDout));

  p_ce_only_on_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostWr) |-> $stable(flashCeN));
endmodule

// File: tb/nand_reg_bridge_test.sv
module nand_reg_bridge_test;
  localparam int PW = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostWait;
  logic        flashCeN, flashCle, flashAle, flashWeN, flashReN, flashDoutEn;
  logic [7:0]  flashDout;
  logic [7:0]  flashDin = 8'h00;
  logic        flashRbN = 1'b1;

  always #10 clk = ~clk;

  nand_reg_bridge #(.PULSE_CLKS(PW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostWait(hostWait),
    .flashCeN(flashCeN), .flashCle(flashCle), .flashAle(flashAle),
    .flashWeN(flashWeN), .flashReN(flashReN), .flashDout(flashDout),
    .flashDoutEn(flashDoutEn), .flashDin(flashDin), .flashRbN(flashRbN)
  );

  int total = 0;
  int bad = 0;
  bit checkOn = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: a queue of expected pin states, one per clock.
  typedef struct packed {
    logic cle, ale, weN, reN, oe, busy, cap;
    logic [7:0] dout;
  } vec_t;
  localparam vec_t IDLE_V = '{cle:1'b0, ale:1'b0, weN:1'b1, reN:1'b1, oe:1'b0,
                              busy:1'b0, cap:1'b0, dout:8'h00};
  vec_t q[$];
  vec_t curV = IDLE_V;
  bit   mArmed = 0, mCe = 0, mRdy = 0, rb1 = 1, rb2 = 1;
  logic [7:0] mData = 8'h00;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); curV = IDLE_V; mArmed = 0; mCe = 0; mRdy = 0;
      rb1 = 1; rb2 = 1; mData = 8'h00;
    end else begin
      bit idleNow, newRdy;
      logic [2:0] op;
      vec_t v;
      idleNow = !curV.busy;
      newRdy  = 0;
      if (curV.cap) begin mData = flashDin; newRdy = 1; end
      rb2 = rb1; rb1 = flashRbN;
      op = hostWdata[30:28];
      if (idleNow && hostWr) begin
        if (op < 4) mCe = hostWdata[31];
        mArmed = (op == 3'd2);
        if (op == 3'd0 || op == 3'd1 || op == 3'd3) begin
          v = IDLE_V; v.busy = 1; v.oe = 1; v.dout = hostWdata[23:16];
          v.cle = (op == 3'd0); v.ale = (op == 3'd1);
          q.push_back(v);
          for (int i = 0; i < PW; i++) begin v.weN = 0; q.push_back(v); end
          v.weN = 1; q.push_back(v);
        end
      end else if (idleNow && hostRd && mArmed && !mRdy) begin
        v = IDLE_V; v.busy = 1;
        q.push_back(v);
        for (int i = 0; i < PW; i++) begin
          v.reN = 0; v.cap = (i == PW - 1); q.push_back(v);
        end
      end
      curV = (q.size() > 0) ? q.pop_front() : IDLE_V;
      mRdy = newRdy;
    end
  end

  int weFalls = 0, reFalls = 0, cleCyc = 0, aleCyc = 0, weLowCyc = 0;
  logic prevWe = 1'b1, prevRe = 1'b1;

  always @(negedge clk) begin
    if (checkOn) begin
      logic expWait;
      logic [31:0] expWord;
      expWait = curV.busy || (hostRd && !hostWr && mArmed && !mRdy);
      expWord = {8'h00, mData, !rb2, 15'h0000};
      check(flashCle === curV.cle, "R2", "cle", flashCle, curV.cle);
      check(flashAle === curV.ale, "R3", "ale", flashAle, curV.ale);
      check(flashWeN === curV.weN, "R5", "weN", flashWeN, curV.weN);
      check(flashReN === curV.reN, "R8", "reN", flashReN, curV.reN);
      check(flashDoutEn === curV.oe, "R5", "doutEn", flashDoutEn, curV.oe);
      if (curV.oe) check(flashDout === curV.dout, "R5", "dout", flashDout, curV.dout);
      check(flashCeN === !mCe, "R6", "ceN", flashCeN, !mCe);
      check(hostWait === expWait, "R7", "wait", hostWait, expWait);
      check(hostRdata === expWord, "R10", "rdata", hostRdata, expWord);
      if (prevWe && !flashWeN) weFalls++;
      if (prevRe && !flashReN) reFalls++;
      if (flashCle) cleCyc++;
      if (flashAle) aleCyc++;
      if (!flashWeN) weLowCyc++;
      prevWe = flashWeN;
      prevRe = flashReN;
    end
  end

  task automatic wrReg(input logic [2:0] op, input logic ce, input logic [7:0] b);
    @(negedge clk); #1;
    hostWr = 1'b1; hostWdata = {ce, op, 4'h0, b, 16'h0000};
    #1;
    while (hostWait) begin @(negedge clk); #2; end
    @(negedge clk); #1;
    hostWr = 1'b0; hostWdata = '0;
  endtask

  task automatic rdReg(output logic [31:0] word);
    @(negedge clk); #1;
    hostRd = 1'b1;
    #1;
    while (hostWait) begin @(negedge clk); #2; end
    word = hostRdata;
    @(negedge clk); #1;
    hostRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int w0, r0, c0, a0, l0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(hostRdata === 32'h0, "R1", "rdata", hostRdata, 0);
    check(flashWeN === 1'b1 && flashReN === 1'b1 && flashCeN === 1'b1, "R1", "strobes",
          {flashWeN, flashReN, flashCeN}, 3'b111);
    check(flashCle === 1'b0 && flashAle === 1'b0 && flashDoutEn === 1'b0 && hostWait === 1'b0,
          "R1", "levels", {flashCle, flashAle, flashDoutEn, hostWait}, 0);
    checkOn = 1;

    // R2 command cycle
    w0 = weFalls; c0 = cleCyc; l0 = weLowCyc;
    wrReg(3'd0, 1'b1, 8'h70); idle(6);
    check(weFalls - w0 == 1, "R2", "we pulses", weFalls - w0, 1);
    check(cleCyc - c0 == PW + 2, "R2", "cle cycles", cleCyc - c0, PW + 2);
    check(weLowCyc - l0 == PW, "R5", "we low cycles", weLowCyc - l0, PW);
    check(flashCeN === 1'b0, "R6", "ce low", flashCeN, 0);

    // R3 and R7: two address writes back to back, the second one held
    w0 = weFalls; a0 = aleCyc;
    wrReg(3'd1, 1'b1, 8'h12);
    wrReg(3'd1, 1'b1, 8'h34); idle(6);
    check(weFalls - w0 == 2, "R7", "held write pulses", weFalls - w0, 2);
    check(aleCyc - a0 == 2 * (PW + 2), "R3", "ale cycles", aleCyc - a0, 2 * (PW + 2));

    // R4 data write
    w0 = weFalls; c0 = cleCyc; a0 = aleCyc;
    wrReg(3'd3, 1'b1, 8'hA5); idle(6);
    check(weFalls - w0 == 1, "R4", "we pulses", weFalls - w0, 1);
    check(cleCyc - c0 == 0 && aleCyc - a0 == 0, "R4", "cle/ale", (cleCyc - c0) + (aleCyc - a0), 0);

    // R8 read mode, successive reads with no write between
    w0 = weFalls; r0 = reFalls;
    wrReg(3'd2, 1'b1, 8'h00); idle(2);
    check(weFalls - w0 == 0, "R8", "arm makes no write", weFalls - w0, 0);
    flashDin = 8'h3C;
    rdReg(w);
    check(w[23:16] === 8'h3C, "R8", "first byte", w[23:16], 8'h3C);
    flashDin = 8'hC3;
    rdReg(w);
    check(w[23:16] === 8'hC3, "R8", "second byte", w[23:16], 8'hC3);
    check(reFalls - r0 == 2, "R8", "re pulses", reFalls - r0, 2);

    // R12 data write disarms; R9 unarmed read returns last byte with no strobe
    wrReg(3'd3, 1'b1, 8'h11); idle(4);
    r0 = reFalls; flashDin = 8'h99;
    rdReg(w); idle(3);
    check(reFalls - r0 == 0, "R12", "re after write", reFalls - r0, 0);
    check(w[23:16] === 8'hC3, "R9", "stale byte", w[23:16], 8'hC3);

    // R11 ignored opcode: no cycle, CE kept, read mode cleared
    wrReg(3'd2, 1'b1, 8'h00);
    w0 = weFalls; r0 = reFalls;
    wrReg(3'd5, 1'b0, 8'h55); idle(3);
    check(weFalls - w0 == 0, "R11", "no cycle", weFalls - w0, 0);
    check(flashCeN === 1'b0, "R11", "ce kept", flashCeN, 0);
    rdReg(w); idle(3);
    check(reFalls - r0 == 0, "R11", "disarmed", reFalls - r0, 0);

    // R6 chip-enable released
    wrReg(3'd0, 1'b0, 8'hFF); idle(6);
    check(flashCeN === 1'b1, "R6", "ce high", flashCeN, 1);

    // R10 busy flag through the synchroniser
    @(negedge clk); #1 flashRbN = 1'b0;
    @(negedge clk);
    check(hostRdata[15] === 1'b0, "R10", "busy after 1 edge", hostRdata[15], 0);
    @(negedge clk);
    check(hostRdata[15] === 1'b1, "R10", "busy after 2 edges", hostRdata[15], 1);
    #1 flashRbN = 1'b1;
    idle(3);
    check(hostRdata[15] === 1'b0, "R10", "ready again", hostRdata[15], 0);

    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule